// File: doc/BRIEF.md
# Additive LFSR Bit Scrambler

This block whitens a bit-serial data stream before it reaches a multi-level line encoder. Long runs of identical bits are broken up, which lowers the regularity of the line signal and the strength of its harmonics. An 11-stage feedback shift register produces a pseudo-random bit sequence. Every valid input bit is XORed with the current sequence bit, and the result is presented one cycle later.

The receiver uses the same module with the role parameter set to the receive side. It holds the same seed and advances in step with the received valid bits. A second XOR with the same sequence returns the original data. The role parameter only selects the reset seed that is used. The datapath is identical for both roles, because XORing twice with the same bit cancels.

Software, or a link controller, can load a seed at any time through a synchronous load strobe. A seed of all zeros would freeze the register, so such a seed is replaced by all ones.

Top module: `lfsr_scrambler`

## Requirements
- R1: While reset is held, and after it is released, `out_valid` and `out_data` are 0. The register starts from the role's reset seed, which is all ones by default.
- R2: For each cycle in which `in_valid` is 1, `out_data` in the next cycle equals `in_data` XOR register bit 10. Bit 10 is the most significant stage, read before that cycle's update.
- R3: `out_valid` equals `in_valid` delayed by exactly one clock cycle.
- R4: On each valid cycle without a load, the register shifts one place toward bit 10. The new bit 0 is bit 10 XOR bit 8, which gives the polynomial x^11 + x^9 + 1.
- R5: When `in_valid` and `seed_load` are both 0, the register holds its value. An idle gap therefore does not move the sequence.
- R6: When `seed_load` is 1 and `seed` is nonzero, the register takes `seed` at the next clock edge.
- R7: A load of `seed` = 0 places all ones in the register.
- R8: When `seed_load` and `in_valid` are both 1 in the same cycle, the data bit is scrambled with the register value from before the load. The load then takes precedence over the shift.
- R9: A receive-side instance with the same seed recovers the original bits. Its input is the scrambler output, and its load is one cycle behind the transmit load, which matches the pipeline delay.
- R10: The register never holds all zeros. Scrambling 2047 consecutive zero bits yields exactly 1024 ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| seed_load | input | 1 | Synchronous strobe that loads `seed` into the register |
| seed | input | 11 | Seed value; zero is replaced by all ones |
| in_valid | input | 1 | Input bit qualifier; advances the register |
| in_data | input | 1 | Serial input bit |
| out_valid | output | 1 | Output bit qualifier, one cycle after `in_valid` |
| out_data | output | 1 | Scrambled (or descrambled) output bit |

## Verification
The bench uses the default 11-stage register with taps at stages 10 and 8, a two-flop reset synchronizer, and all-ones reset seeds. It places a transmit-role instance in front of a receive-role instance. These defaults make the whole 2047-bit period short enough to run end to end, which exposes a wrong tap or a lock-up through the count of ones. The chained receiver, which has the receive-role seed selection, shows whether both roles stay aligned across idle gaps, zero seeds and loads that coincide with data.

// File: rtl/scr_pkg.sv
package scr_pkg;
  typedef enum logic {
    ROLE_TX = 1'b0,
    ROLE_RX = 1'b1
  } scr_role_e;
endpackage

// File: rtl/scr_reset_sync.sv
module scr_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/scr_seed_guard.sv
module scr_seed_guard #(
  parameter int W = 11
) (
  input  logic [W-1:0] seed_in,
  output logic [W-1:0] seed_safe
);
  always_comb begin
    if (seed_in == '0) seed_safe = '1;
    else               seed_safe = seed_in;
  end
endmodule

// File: rtl/scr_lfsr_core.sv
module scr_lfsr_core #(
  parameter int          W        = 11,
  parameter int          TAP_HI   = 10,
  parameter int          TAP_LO   = 8,
  parameter logic [W-1:0] RST_SEED = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         advance,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] state,
  output logic         prbs_bit
);
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;
  logic         fb_bit;

  always_comb fb_bit = state_q[TAP_HI] ^ state_q[TAP_LO];

  always_comb begin
    state_d = state_q;
    if (load)         state_d = load_val;
    else if (advance) state_d = {state_q[W-2:0], fb_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                state_q <= RST_SEED;
    else if (load || advance)  state_q <= state_d;
  end

  assign state    = state_q;
  assign prbs_bit = state_q[W-1];

  // R10: the register never reaches the lock-up value
  assert_no_lockup_R10: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

  // R5: no load and no valid bit leaves the register untouched
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !load) |=> $stable(state_q));

  // R4: a plain advance moves every stage one place toward the top
  assert_shift_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> (state_q[W-1:1] == $past(state_q[W-2:0])));

  // R6, R8: a load wins over a shift
  assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (state_q == $past(load_val)));
endmodule

// File: rtl/scr_mix_stage.sv
module scr_mix_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_data,
  input  logic prbs_bit,
  output logic out_valid,
  output logic out_data
);
  logic valid_q;
  logic data_q;
  logic data_d;

  always_comb data_d = in_data ^ prbs_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data_q <= 1'b0;
    else if (in_valid) data_q <= data_d;
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;

  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  // R3: qualifier is the input qualifier one cycle late
  assert_valid_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (out_valid == $past(in_valid)));

  // R2: the emitted bit is the input bit combined with the sequence bit
  assert_data_mix_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_data == ($past(in_data) ^ $past(prbs_bit))));
endmodule

// File: rtl/lfsr_scrambler.sv
module lfsr_scrambler #(
  parameter int                 W             = 11,
  parameter int                 TAP_HI        = 10,
  parameter int                 TAP_LO        = 8,
  parameter int                 SYNC_STAGES   = 2,
  parameter scr_pkg::scr_role_e ROLE          = scr_pkg::ROLE_TX,
  parameter logic [W-1:0]       TX_RESET_SEED = '1,
  parameter logic [W-1:0]       RX_RESET_SEED = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         seed_load,
  input  logic [W-1:0] seed,
  input  logic         in_valid,
  input  logic         in_data,
  output logic         out_valid,
  output logic         out_data
);
  localparam logic [W-1:0] ROLE_SEED_RAW =
    (ROLE == scr_pkg::ROLE_TX) ? TX_RESET_SEED : RX_RESET_SEED;
  localparam logic [W-1:0] ROLE_SEED = (ROLE_SEED_RAW == '0) ? '1 : ROLE_SEED_RAW;

  logic         rst_n_int;
  logic [W-1:0] seed_safe;
  logic [W-1:0] lfsr_state;
  logic         prbs_bit;

  scr_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  scr_seed_guard #(.W(W)) u_guard (
    .seed_in   (seed),
    .seed_safe (seed_safe)
  );

  scr_lfsr_core #(
    .W        (W),
    .TAP_HI   (TAP_HI),
    .TAP_LO   (TAP_LO),
    .RST_SEED (ROLE_SEED)
  ) u_lfsr (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .advance  (in_valid),
    .load     (seed_load),
    .load_val (seed_safe),
    .state    (lfsr_state),
    .prbs_bit (prbs_bit)
  );

  scr_mix_stage u_mix (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .prbs_bit  (prbs_bit),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  // R7: a zero seed ends up as all ones
  assert_zero_seed_R7: assert property (@(posedge clk) disable iff (!rst_n_int)
    (seed_load && (seed == '0)) |=> (lfsr_state == '1));

  // R6: a nonzero seed is taken unchanged
  assert_seed_taken_R6: assert property (@(posedge clk) disable iff (!rst_n_int)
    (seed_load && (seed != '0)) |=> (lfsr_state == $past(seed)));
endmodule

// File: tb/lfsr_scrambler_test.sv
module lfsr_scrambler_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_load = 1'b0;
  logic [W-1:0] tx_seed = '0;
  logic rx_load = 1'b0;
  logic [W-1:0] rx_seed = '0;
  logic in_valid = 1'b0;
  logic in_data = 1'b0;
  logic tx_valid, tx_data, rx_valid, rx_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  lfsr_scrambler #(.ROLE(scr_pkg::ROLE_TX)) uut (
    .clk(clk), .rst_n(rst_n), .seed_load(tx_load), .seed(tx_seed),
    .in_valid(in_valid), .in_data(in_data),
    .out_valid(tx_valid), .out_data(tx_data));

  lfsr_scrambler #(.ROLE(scr_pkg::ROLE_RX)) rx_uut (
    .clk(clk), .rst_n(rst_n), .seed_load(rx_load), .seed(rx_seed),
    .in_valid(tx_valid), .in_data(tx_data),
    .out_valid(rx_valid), .out_data(rx_data));

  int checks = 0;
  int errors = 0;
  logic txq[$];
  logic rxq[$];
  logic [W-1:0] model = '1;
  logic pend_load = 1'b0;
  logic [W-1:0] pend_seed = '0;
  bit mon_en = 1'b0;
  bit cnt_en = 1'b0;
  int ones_cnt = 0;
  string cur_req = "R1";

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one driver cycle; the receive seed load trails the transmit one by a cycle
  task automatic step(input logic v, input logic d, input logic ld, input logic [W-1:0] sd);
    @(negedge clk);
    rx_load = pend_load;
    rx_seed = pend_seed;
    pend_load = ld;
    pend_seed = sd;
    tx_load = ld;
    tx_seed = sd;
    in_valid = v;
    in_data = d;
    if (v) begin
      txq.push_back(d ^ model[W-1]);
      rxq.push_back(d);
    end
    if (ld) model = (sd == '0) ? '1 : sd;
    else if (v) model = {model[W-2:0], model[10] ^ model[8]};
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, '0);
  endtask

  always @(posedge clk) begin
    #2;
    if (mon_en) begin
      check(tx_valid == in_valid, "R3", tx_valid, in_valid);
      if (tx_valid) begin
        if (txq.size() == 0) check(1'b0, cur_req, 1, 0);
        else begin
          automatic logic e = txq.pop_front();
          check(tx_data == e, cur_req, tx_data, e);
        end
        if (cnt_en) ones_cnt += tx_data;
      end
      if (rx_valid) begin
        if (rxq.size() == 0) check(1'b0, "R9", 1, 0);
        else begin
          automatic logic e = rxq.pop_front();
          check(rx_data == e, "R9", rx_data, e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    check(tx_valid == 1'b0, "R1", tx_valid, 0);
    check(tx_data == 1'b0, "R1", tx_data, 0);
    check(rx_valid == 1'b0, "R1", rx_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(tx_valid == 1'b0 && tx_data == 1'b0, "R1", tx_valid, 0);
    mon_en = 1'b1;

    // R1/R2/R4: default seed, zero input exposes the raw sequence
    cur_req = "R4";
    for (int i = 0; i < 30; i++) step(1'b1, 1'b0, 1'b0, '0);
    cur_req = "R2";
    for (int i = 0; i < 30; i++) step(1'b1, 1'((i * 7) % 3 == 1), 1'b0, '0);

    // R5: gaps must not move the sequence
    cur_req = "R5";
    for (int i = 0; i < 12; i++) begin
      step(1'b1, 1'(i % 2), 1'b0, '0);
      idle(i % 4 + 1);
    end

    // R6: nonzero seed
    cur_req = "R6";
    idle(2);
    step(1'b0, 1'b0, 1'b1, 11'h2A5);
    idle(2);
    for (int i = 0; i < 40; i++) step(1'b1, 1'((i % 5) < 2), 1'b0, '0);

    // R7: zero seed behaves as all ones
    cur_req = "R7";
    idle(2);
    step(1'b0, 1'b0, 1'b1, '0);
    idle(2);
    for (int i = 0; i < 30; i++) step(1'b1, 1'b1, 1'b0, '0);

    // R8: load together with a data bit
    cur_req = "R8";
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b0, '0);
    step(1'b1, 1'b0, 1'b1, 11'h123);
    for (int i = 0; i < 20; i++) step(1'b1, 1'(i % 3 == 0), 1'b0, '0);

    // R10: one full period of zeros from a fresh seed
    cur_req = "R10";
    idle(2);
    step(1'b0, 1'b0, 1'b1, 11'h001);
    idle(2);
    @(negedge clk);
    ones_cnt = 0;
    cnt_en = 1'b1;
    for (int i = 0; i < 2047; i++) step(1'b1, 1'b0, 1'b0, '0);
    idle(1);
    @(negedge clk);
    cnt_en = 1'b0;
    check(ones_cnt == 1024, "R10", ones_cnt, 1024);

    idle(4);
    check(txq.size() == 0, "R2", txq.size(), 0);
    check(rxq.size() == 0, "R9", rxq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule